// File: doc/BRIEF.md
# Memory Read Sequencer with CRC16

This block is the command engine of a slave on a bit-serial single-wire bus. A time-slot layer in front of it turns line activity into three kinds of single-cycle events: a received bit, a request for a bit to send (a read slot), and a reset pulse. The engine collects a one-byte command and a two-byte start address, both least significant bit first. If the command is the read command 0xF0 and the address lies inside the 128-byte data memory, it streams memory contents one bit per read slot. It starts at the given address and stops after byte 127. The memory sits outside the block behind a synchronous read port.

A 16-bit CRC runs over the command byte, the low and the high address byte, and every data byte sent, in that order. The CRC is sent only when a read reaches the end of memory. Its sixteen bits follow the last data bit, and after them every read slot returns 1. A reset pulse at any point drops the sequence, and the CRC with it, and the engine waits for a new command. To keep every read slot answered at once, the memory read for the next byte is issued ahead of need, during the current byte.

Top module: `mrd_seq`

## Requirements
- R1: After `rst`, or in the cycle after a `bus_rst_i` pulse, the engine waits for a command, `bit_out_o` is 1 and `mem_re_o` is 0.
- R2: The 8 bits received after a reset form the command byte, LSB first. Only the value 0xF0 starts a read. Any other value makes every read slot return 1, and received bits are ignored until the next reset.
- R3: After 0xF0, the next 16 received bits are the start address: low byte first, then high byte, each LSB first. Each later read slot returns the next data bit. Data starts at the start address, each byte is sent LSB first, and the address advances one byte at a time.
- R4: A read slot that comes before the first data bit is ready returns 1 and does not advance the sequence. This covers slots during the command, during the address, and while the first byte is being fetched.
- R5: If address bit 7 or any of bits 15:8 is set, every read slot returns 1 until the next reset, and the memory is never read.
- R6: After the last bit of byte 127, the next 16 read slots return the bitwise inverse of a CRC, LSB first. The CRC uses polynomial x^16+x^15+x^2+1 with a zero seed. It is updated bit by bit, LSB first (right shift, reflected constant 0xA001), over the command byte, the low address byte, the high address byte, and each data byte.
- R7: Once the 16 CRC bits have gone out, every read slot returns 1 until the next reset.
- R8: A reset pulse in the middle of a read ends it at once, with no CRC. A following command runs with a freshly cleared CRC.
- R9: Each memory read is a one-cycle `mem_re_o` pulse. The data must appear on `mem_rdata_i` in the following cycle. Read slots may come every 4 clock cycles with no data bit delayed.
- R10: Bits received while data or CRC are being sent have no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_i | input | 1 | One-cycle strobe: reset pulse seen on the bus |
| bit_in_vld_i | input | 1 | One-cycle strobe: a bit was received |
| bit_in_i | input | 1 | Value of the received bit |
| slot_req_i | input | 1 | One-cycle strobe: the layer consumes `bit_out_o` for a read slot |
| bit_out_o | output | 1 | Bit answered on the current read slot (registered) |
| mem_re_o | output | 1 | Memory read enable, one-cycle pulse |
| mem_addr_o | output | 7 | Memory byte address |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after `mem_re_o` |

## Verification
The hardest situation to reach from the ports is a read that runs through the end of memory but was preceded by traffic the engine must not count. Examples are read slots sent during the address bytes, received bits during the data phase, or an aborted read before it. The CRC and the data bytes are the only evidence of whether that traffic leaked into the state. The bench mixes these disturbances into full reads and computes the expected CRC on its own, over the command, address and modelled memory contents. Start addresses 0x7E and 0x7F are used so that the prefetch path and the turn from data to CRC meet within a byte or two.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_FETCH = 3'd2,
    ST_DATA  = 3'd3,
    ST_CRC   = 3'd4,
    ST_ONES  = 3'd5
  } seq_state_e;

endpackage

// File: rtl/mrd_rx_deser.sv
module mrd_rx_deser #(
  parameter int RX_W = 24,
  localparam int CW  = $clog2(RX_W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            en,
  input  logic            bit_i,
  output logic [CW-1:0]   cnt_o,
  output logic [RX_W-1:0] data_nxt_o
);

  logic [RX_W-1:0] data_q;
  logic [CW-1:0]   cnt_q;

  // Bits arrive LSB first: shift in at the top, so after RX_W bits the
  // first bit sits at index 0.
  assign data_nxt_o = {bit_i, data_q[RX_W-1:1]};
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      data_q <= data_nxt_o;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mrd_crc16.sv
module mrd_crc16 #(
  parameter int             CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY_R = 16'hA001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [CRC_W-1:0] crc_nxt_o
);

  logic [CRC_W-1:0] crc_q;
  logic             fb;

  // Reflected, LSB-first serial update.
  assign fb        = crc_q[0] ^ bit_i;
  assign crc_nxt_o = (crc_q >> 1) ^ (fb ? POLY_R : '0);
  assign crc_o     = crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      crc_q <= '0;
    else if (en)
      crc_q <= crc_nxt_o;
  end

endmodule

// File: rtl/mrd_seq.sv
module mrd_seq
  import mrd_pkg::*;
#(
  parameter int               ADDR_W   = 7,
  parameter int               DATA_W   = 8,
  parameter int               CMD_W    = 8,
  parameter int               ADR_BITS = 16,
  parameter logic [CMD_W-1:0] CMD_READ = 8'hF0,
  parameter int               CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rst_i,
  input  logic              bit_in_vld_i,
  input  logic              bit_in_i,
  input  logic              slot_req_i,
  output logic              bit_out_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int RX_W   = CMD_W + ADR_BITS;
  localparam int RX_CW  = $clog2(RX_W + 1);
  localparam int BIT_CW = $clog2(DATA_W);
  localparam int CC_W   = $clog2(CRC_W);
  localparam logic [RX_CW-1:0]  CMD_LAST  = RX_CW'(CMD_W - 1);
  localparam logic [RX_CW-1:0]  ADR_LAST  = RX_CW'(RX_W - 1);
  localparam logic [BIT_CW-1:0] BIT_PRE   = BIT_CW'(DATA_W - 2);
  localparam logic [BIT_CW-1:0] BIT_LAST  = BIT_CW'(DATA_W - 1);
  localparam logic [CC_W-1:0]   CRC_LAST  = CC_W'(CRC_W - 1);
  localparam logic [ADDR_W-1:0] BYTE_LAST = ADDR_W'((2 ** ADDR_W) - 1);

  seq_state_e         state_q, state_d;
  logic [DATA_W-1:0]  tx_q, tx_d;
  logic [DATA_W-1:0]  hold_q;
  logic [BIT_CW-1:0]  bidx_q, bidx_d;
  logic [ADDR_W-1:0]  baddr_q, baddr_d;
  logic [ADDR_W-1:0]  raddr_q, raddr_d;
  logic [CRC_W-1:0]   crcsh_q, crcsh_d;
  logic [CC_W-1:0]    ccnt_q, ccnt_d;
  logic               re_q, re_d;
  logic               rd_pend_q;
  logic               out_q, out_d;

  // receive side
  logic              rx_en;
  logic [RX_CW-1:0]  rx_cnt;
  logic [RX_W-1:0]   rx_nxt;
  logic [CMD_W-1:0]  cmd_byte;
  logic [ADR_BITS-1:0] start_adr;
  logic              adr_bad;

  // crc side
  logic              crc_en;
  logic              crc_bit;
  logic [CRC_W-1:0]  crc_cur;
  logic [CRC_W-1:0]  crc_nxt;

  logic in_rx_phase;
  assign in_rx_phase = (state_q == ST_CMD) || (state_q == ST_ADDR);
  assign rx_en       = bit_in_vld_i && !bus_rst_i && in_rx_phase;

  mrd_rx_deser #(.RX_W(RX_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .clr        (bus_rst_i),
    .en         (rx_en),
    .bit_i      (bit_in_i),
    .cnt_o      (rx_cnt),
    .data_nxt_o (rx_nxt)
  );

  // After CMD_W bits the command occupies the top of the shifter; after
  // RX_W bits it sits at the bottom and the address above it.
  assign cmd_byte  = rx_nxt[RX_W-1 -: CMD_W];
  assign start_adr = rx_nxt[RX_W-1 -: ADR_BITS];
  assign adr_bad   = |start_adr[ADR_BITS-1:ADDR_W];

  assign crc_en  = !bus_rst_i &&
                   (rx_en || (slot_req_i && state_q == ST_DATA));
  assign crc_bit = (state_q == ST_DATA) ? tx_q[0] : bit_in_i;

  mrd_crc16 #(.CRC_W(CRC_W), .POLY_R(CRC_POLY)) u_crc (
    .clk       (clk),
    .rst       (rst),
    .clr       (bus_rst_i),
    .en        (crc_en),
    .bit_i     (crc_bit),
    .crc_o     (crc_cur),
    .crc_nxt_o (crc_nxt)
  );

  always_comb begin
    state_d = state_q;
    tx_d    = tx_q;
    bidx_d  = bidx_q;
    baddr_d = baddr_q;
    raddr_d = raddr_q;
    crcsh_d = crcsh_q;
    ccnt_d  = ccnt_q;
    re_d    = 1'b0;

    if (bus_rst_i) begin
      state_d = ST_CMD;
      tx_d    = '1;
      bidx_d  = '0;
      baddr_d = '0;
      crcsh_d = '1;
      ccnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_CMD: begin
          if (bit_in_vld_i && rx_cnt == CMD_LAST)
            state_d = (cmd_byte == CMD_READ) ? ST_ADDR : ST_ONES;
        end
        ST_ADDR: begin
          if (bit_in_vld_i && rx_cnt == ADR_LAST) begin
            if (adr_bad) begin
              state_d = ST_ONES;
            end else begin
              re_d    = 1'b1;
              raddr_d = start_adr[ADDR_W-1:0];
              baddr_d = start_adr[ADDR_W-1:0];
              state_d = ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (rd_pend_q) begin
            tx_d    = mem_rdata_i;
            bidx_d  = '0;
            state_d = ST_DATA;
          end
        end
        ST_DATA: begin
          if (slot_req_i) begin
            tx_d   = {1'b1, tx_q[DATA_W-1:1]};
            bidx_d = bidx_q + 1'b1;
            if (bidx_q == BIT_PRE && baddr_q != BYTE_LAST) begin
              re_d    = 1'b1;
              raddr_d = baddr_q + 1'b1;
            end
            if (bidx_q == BIT_LAST) begin
              bidx_d = '0;
              if (baddr_q == BYTE_LAST) begin
                crcsh_d = ~crc_nxt;
                ccnt_d  = '0;
                state_d = ST_CRC;
              end else begin
                tx_d    = hold_q;
                baddr_d = baddr_q + 1'b1;
              end
            end
          end
        end
        ST_CRC: begin
          if (slot_req_i) begin
            crcsh_d = {1'b1, crcsh_q[CRC_W-1:1]};
            ccnt_d  = ccnt_q + 1'b1;
            if (ccnt_q == CRC_LAST)
              state_d = ST_ONES;
          end
        end
        default: state_d = ST_ONES;
      endcase
    end

    unique case (state_d)
      ST_DATA: out_d = tx_d[0];
      ST_CRC:  out_d = crcsh_d[0];
      default: out_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_CMD;
      tx_q      <= '1;
      bidx_q    <= '0;
      baddr_q   <= '0;
      raddr_q   <= '0;
      crcsh_q   <= '1;
      ccnt_q    <= '0;
      re_q      <= 1'b0;
      rd_pend_q <= 1'b0;
      out_q     <= 1'b1;
    end else begin
      state_q   <= state_d;
      tx_q      <= tx_d;
      bidx_q    <= bidx_d;
      baddr_q   <= baddr_d;
      raddr_q   <= raddr_d;
      crcsh_q   <= crcsh_d;
      ccnt_q    <= ccnt_d;
      re_q      <= re_d;
      rd_pend_q <= re_q && !bus_rst_i;
      out_q     <= out_d;
    end
  end

  // prefetch holding register: captures memory data the cycle it is valid
  always_ff @(posedge clk) begin
    if (rst)
      hold_q <= '1;
    else if (rd_pend_q)
      hold_q <= mem_rdata_i;
  end

  assign bit_out_o  = out_q;
  assign mem_re_o   = re_q;
  assign mem_addr_o = raddr_q;

  // R1
  bus_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rst_i |=> (bit_out_o && !mem_re_o && state_q == ST_CMD));

  // R9
  mem_re_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re_o |=> !mem_re_o);

  // R4
  early_slot_one_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CMD || state_q == ST_ADDR || state_q == ST_FETCH) |-> bit_out_o);

  // R7
  tail_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONES && slot_req_i && !bus_rst_i) |=> bit_out_o);

  // R3
  hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && !slot_req_i && !bus_rst_i) |=> $stable(bit_out_o));

  // R5
  no_read_when_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONES) |-> !mem_re_o);

endmodule

// File: tb/mrd_seq_bench.sv
module mrd_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rst_i = 1'b0;
  logic       bit_in_vld_i = 1'b0;
  logic       bit_in_i = 1'b0;
  logic       slot_req_i = 1'b0;
  logic       bit_out_o;
  logic       mem_re_o;
  logic [6:0] mem_addr_o;
  logic [7:0] mem_rdata_i = 8'h00;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mrd_seq u_mrd_seq (
    .clk         (clk),
    .rst         (rst),
    .bus_rst_i   (bus_rst_i),
    .bit_in_vld_i(bit_in_vld_i),
    .bit_in_i    (bit_in_i),
    .slot_req_i  (slot_req_i),
    .bit_out_o   (bit_out_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i)
  );

  function automatic logic [7:0] mem_val(int i);
    return 8'((i * 29 + 91) ^ (i << 5));
  endfunction

  // synchronous-read memory model
  always_ff @(posedge clk)
    if (mem_re_o) mem_rdata_i <= mem_val(int'(mem_addr_o));

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      logic fb;
      fb = c[0] ^ b[k];
      c  = (c >> 1) ^ (fb ? 16'hA001 : 16'h0000);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in_i = b; bit_in_vld_i = 1'b1;
    @(negedge clk); bit_in_vld_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) send_bit(v[k]);
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst_i = 1'b1;
    @(negedge clk); bus_rst_i = 1'b0;
  endtask

  // sample the answered bit, then consume it; 4 cycles per slot
  task automatic do_slot(output logic b);
    @(negedge clk); b = bit_out_o; slot_req_i = 1'b1;
    @(negedge clk); slot_req_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_bits(input int n, output logic [15:0] v);
    v = '0;
    for (int k = 0; k < n; k++) begin
      logic b;
      do_slot(b);
      v[k] = b;
    end
  endtask

  task automatic start_cmd(input logic [7:0] cmd, input logic [15:0] adr);
    pulse_bus_rst();
    send_byte(cmd);
    send_byte(adr[7:0]);
    send_byte(adr[15:8]);
    repeat (3) @(negedge clk);
  endtask

  // read from adr to end, then CRC and trailing ones
  task automatic read_to_end(input logic [7:0] cmd, input logic [15:0] adr,
                             input string req);
    logic [15:0] crc, v;
    crc = crc_byte(16'h0000, cmd);
    crc = crc_byte(crc, adr[7:0]);
    crc = crc_byte(crc, adr[15:8]);
    for (int a = int'(adr); a < 128; a++) begin
      read_bits(8, v);
      chk(v[7:0] == mem_val(a), {req, " data"}, v, {8'h00, mem_val(a)});
      crc = crc_byte(crc, mem_val(a));
    end
    read_bits(16, v);
    chk(v == ~crc, "R6 crc", v, ~crc);
    read_bits(8, v);
    chk(v[7:0] == 8'hFF, "R7 ones after crc", v, 16'h00FF);
  endtask

  localparam logic [23:0] VEC [0:6] = '{
    {8'hF0, 16'h0000},
    {8'hF0, 16'h0070},
    {8'hF0, 16'h007F},
    {8'hF0, 16'h0080},
    {8'hF0, 16'h0100},
    {8'hAA, 16'h0000},
    {8'hF0, 16'h0045}
  };

  initial begin
    logic [15:0] v;
    logic b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bit_out_o == 1'b1, "R1 reset bit_out", {15'd0, bit_out_o}, 16'd1);
    chk(mem_re_o == 1'b0, "R1 reset mem_re", {15'd0, mem_re_o}, 16'd0);

    // table walk: R3 R5 R6 R2 R9
    for (int i = 0; i < 7; i++) begin
      logic [7:0]  cmd;
      logic [15:0] adr;
      cmd = VEC[i][23:16];
      adr = VEC[i][15:0];
      start_cmd(cmd, adr);
      if (cmd == 8'hF0 && adr[15:7] == 9'd0) begin
        read_to_end(cmd, adr, "R3 R9");
      end else begin
        read_bits(16, v);
        chk(v == 16'hFFFF, (cmd != 8'hF0) ? "R2 bad command" : "R5 bad address",
            v, 16'hFFFF);
      end
    end

    // R2: after a bad command, a following valid sequence is ignored
    pulse_bus_rst();
    send_byte(8'h0F);
    send_byte(8'hF0);
    send_byte(8'h00);
    send_byte(8'h00);
    repeat (3) @(negedge clk);
    read_bits(16, v);
    chk(v == 16'hFFFF, "R2 ignored bits", v, 16'hFFFF);

    // R4: slots during command and address return 1 and do not advance
    pulse_bus_rst();
    send_byte(8'hF0);
    do_slot(b);
    chk(b == 1'b1, "R4 slot after command", {15'd0, b}, 16'd1);
    send_byte(8'h7C);
    do_slot(b);
    chk(b == 1'b1, "R4 slot mid address", {15'd0, b}, 16'd1);
    send_byte(8'h00);
    repeat (3) @(negedge clk);
    read_bits(8, v);
    chk(v[7:0] == mem_val(124), "R4 first byte intact", v, {8'h00, mem_val(124)});
    // R10: received bits during data are ignored
    send_byte(8'h5A);
    begin
      logic [15:0] crc;
      crc = crc_byte(16'h0000, 8'hF0);
      crc = crc_byte(crc, 8'h7C);
      crc = crc_byte(crc, 8'h00);
      crc = crc_byte(crc, mem_val(124));
      for (int a = 125; a < 128; a++) begin
        read_bits(8, v);
        chk(v[7:0] == mem_val(a), "R10 data after stray bits", v, {8'h00, mem_val(a)});
        crc = crc_byte(crc, mem_val(a));
      end
      send_bit(1'b0);
      read_bits(16, v);
      chk(v == ~crc, "R10 crc after stray bits", v, ~crc);
    end

    // R8: abort mid-read, then a fresh read to the end
    start_cmd(8'hF0, 16'h0020);
    read_bits(12, v);
    pulse_bus_rst();
    @(negedge clk);
    chk(bit_out_o == 1'b1, "R8 abort bit_out", {15'd0, bit_out_o}, 16'd1);
    start_cmd(8'hF0, 16'h007E);
    read_to_end(8'hF0, 16'h007E, "R8");

    // R1: bus reset during the CRC phase
    start_cmd(8'hF0, 16'h007F);
    read_bits(12, v);
    pulse_bus_rst();
    chk(bit_out_o == 1'b1, "R1 bus reset in crc", {15'd0, bit_out_o}, 16'd1);
    read_bits(8, v);
    chk(v[7:0] == 8'hFF, "R1 waiting after bus reset", v, 16'h00FF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule